// File: doc/BRIEF.md
# Parallel Flash Bus Front End

This block sits between the pins of a parallel NOR-style flash device and its internal program/erase engine. Each cycle it sorts the four active-low controls (reset, chip enable, output enable, write enable) into one bus operation. A read drives data onto the bus and every other operation leaves the bus released. The reset pin overrides every other control.

The block keeps a persistent read mode, which is array, configuration, status or query. A read returns the data source that belongs to the current mode. The mode changes only when a mode command is written. Write cycles capture the address and data, and the command goes to the engine on the rising edge of write enable, together with the state of the write-protect input. While the engine reports busy, every read returns status, so the host can poll for completion.

The data bus is split into an input, an output and per-byte-lane output enables, so the pad ring can build the tri-state bus. In 8-bit configuration only the low byte lane is used.

Top module: `nor_bus_front`

## Requirements
- R1: While `rst_n_pin` is low, all `dq_oe` lanes are 0 and `cmd_valid` stays 0, whatever the other controls are. Write-enable toggles during reset produce no command, and `read_mode` is forced to array.
- R2: With reset high and `ce_n` high (standby), all `dq_oe` lanes are 0, whatever `oe_n`, `we_n` or `busy` are.
- R3: With reset high, `ce_n` low, `oe_n` high and `we_n` high (output disable), all `dq_oe` lanes are 0.
- R4: With reset high, `ce_n` low, `oe_n` low and `we_n` high (read), the enabled lanes of `dq_out` carry the source for the current read mode: `array_data`, `config_data`, `status_data` or `query_data`.
- R5: During a write cycle (reset high, `ce_n` low, `oe_n` high, `we_n` low), `addr` and `dq_in` are sampled. In the first cycle after `we_n` returns high, `cmd_valid` is 1 for exactly one cycle, and `cmd_addr` and `cmd_data` hold the last sampled values.
- R6: After power-up and after every release of reset, `read_mode` is array (encoding 0).
- R7: The low command byte selects the read mode: 0xFF gives array (0), 0x90 gives configuration (1), 0x70 gives status (2) and 0x98 gives query (3). Any other command leaves `read_mode` unchanged, but the command is still forwarded.
- R8: While `busy` is 1, a read returns `status_data` whatever the read mode is, and the read mode itself is kept.
- R9: `cmd_unlocked` presents the level of `wp` sampled during the write cycle, so the engine allows program or erase of lockable blocks only when it is 1.
- R10: When `byte_mode` is 1, a read enables only lane 0 (`dq_oe` = 01), and the upper byte of `cmd_data` is forced to 0. When `byte_mode` is 0, all lanes are used.
- R11: `ce_n`, `oe_n` and `we_n` all low together is a bus conflict. No lane is driven, and a later rise of `we_n` produces no command.
- R12: `bus_op` encodes the decoded operation as reset 0, standby 1, output disable 2, read 3, write 4, conflict 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n_pin | input | 1 | Reset pin, active low, asynchronous |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| wp | input | 1 | Write-protect level, 1 unlocks lockable blocks |
| byte_mode | input | 1 | 1 selects 8-bit bus configuration |
| addr | input | AW | Bus address |
| dq_in | input | DW | Data from the bus |
| dq_out | output | DW | Data to the bus |
| dq_oe | output | DW/8 | Per-byte-lane output enables |
| array_data | input | DW | Array read source |
| config_data | input | DW | Configuration read source |
| status_data | input | DW | Status read source |
| query_data | input | DW | Query read source |
| busy | input | 1 | Engine busy flag |
| bus_op | output | 3 | Decoded bus operation |
| read_mode | output | 2 | Current read mode |
| cmd_valid | output | 1 | One-cycle command strobe to the engine |
| cmd_addr | output | AW | Latched command address |
| cmd_data | output | DW | Latched command data |
| cmd_unlocked | output | 1 | Write-protect level captured with the command |

## Verification
The assertions check on every cycle that reset and standby leave every lane released, that a command strobe never lasts more than one cycle, that the read mode moves only on a strobe, and that a read while busy carries status. Other behaviour shows up only in the bench's scenarios. These include which command codes move the mode and to where, that the forwarded address and data are the last values seen before write enable rose, and that reset, conflicts and standby swallow a write. They also include byte-lane masking and the return to array mode after a reset pulse.

// File: rtl/nbf_pkg.sv
`timescale 1ns/1ps
package nbf_pkg;

  typedef enum logic [2:0] {
    OP_RESET    = 3'd0,
    OP_STANDBY  = 3'd1,
    OP_OUTDIS   = 3'd2,
    OP_READ     = 3'd3,
    OP_WRITE    = 3'd4,
    OP_CONFLICT = 3'd5
  } bus_op_e;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_CONFIG = 2'd1,
    RM_STATUS = 2'd2,
    RM_QUERY  = 2'd3
  } rd_mode_e;

  localparam logic [7:0] CODE_ARRAY  = 8'hFF;
  localparam logic [7:0] CODE_CONFIG = 8'h90;
  localparam logic [7:0] CODE_STATUS = 8'h70;
  localparam logic [7:0] CODE_QUERY  = 8'h98;

  // Pin levels to bus operation; reset outranks chip enable, which outranks the rest.
  function automatic bus_op_e classify_pins(input logic rst_n, input logic ce_n,
                                            input logic oe_n, input logic we_n);
    if (!rst_n)   return OP_RESET;
    if (ce_n)     return OP_STANDBY;
    if (oe_n)     return we_n ? OP_OUTDIS : OP_WRITE;
    return we_n ? OP_READ : OP_CONFLICT;
  endfunction

  // Mode selected by a command byte; unknown codes keep the present mode.
  function automatic rd_mode_e mode_after(input logic [7:0] code, input rd_mode_e cur);
    case (code)
      CODE_ARRAY:  return RM_ARRAY;
      CODE_CONFIG: return RM_CONFIG;
      CODE_STATUS: return RM_STATUS;
      CODE_QUERY:  return RM_QUERY;
      default:     return cur;
    endcase
  endfunction

endpackage

// File: rtl/nbf_op_decode.sv
`timescale 1ns/1ps
module nbf_op_decode
  import nbf_pkg::*;
(
  input  logic    rst_n,
  input  logic    ce_n,
  input  logic    oe_n,
  input  logic    we_n,
  output bus_op_e op,
  output logic    rd_cycle,
  output logic    wr_cycle
);
  assign op       = classify_pins(rst_n, ce_n, oe_n, we_n);
  assign rd_cycle = (op == OP_READ);
  assign wr_cycle = (op == OP_WRITE);
endmodule

// File: rtl/nbf_cmd_latch.sv
`timescale 1ns/1ps
module nbf_cmd_latch #(
  parameter int AW = 21,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cycle,
  input  logic          we_n,
  input  logic          byte_mode,
  input  logic          wp,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          strobe,
  output logic [AW-1:0] lat_addr,
  output logic [DW-1:0] lat_data,
  output logic          lat_wp
);
  localparam int LANES = DW / 8;

  logic          armed;
  logic [DW-1:0] din_kept;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_low
      assign din_kept[7:0] = din[7:0];
    end else begin : g_high
      assign din_kept[g*8 +: 8] = byte_mode ? 8'h00 : din[g*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      lat_addr <= '0;
      lat_data <= '0;
      lat_wp   <= 1'b0;
    end else begin
      armed <= wr_cycle;
      if (wr_cycle) begin
        lat_addr <= addr;
        lat_data <= din_kept;
        lat_wp   <= wp;
      end
    end
  end

  // Rising edge of write enable that ends a clean write cycle.
  assign strobe = armed && we_n && rst_n;

  assert_one_cycle_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);
endmodule

// File: rtl/nbf_mode_reg.sv
`timescale 1ns/1ps
module nbf_mode_reg
  import nbf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] code,
  output rd_mode_e   mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mode <= RM_ARRAY;
    else if (load) mode <= mode_after(code, mode);
  end

  assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(mode));
endmodule

// File: rtl/nor_bus_front.sv
`timescale 1ns/1ps
module nor_bus_front
  import nbf_pkg::*;
#(
  parameter int AW = 21,
  parameter int DW = 16
) (
  input  logic                clk,
  input  logic                rst_n_pin,
  input  logic                ce_n,
  input  logic                oe_n,
  input  logic                we_n,
  input  logic                wp,
  input  logic                byte_mode,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       dq_in,
  output logic [DW-1:0]       dq_out,
  output logic [DW/8-1:0]     dq_oe,
  input  logic [DW-1:0]       array_data,
  input  logic [DW-1:0]       config_data,
  input  logic [DW-1:0]       status_data,
  input  logic [DW-1:0]       query_data,
  input  logic                busy,
  output logic [2:0]          bus_op,
  output logic [1:0]          read_mode,
  output logic                cmd_valid,
  output logic [AW-1:0]       cmd_addr,
  output logic [DW-1:0]       cmd_data,
  output logic                cmd_unlocked
);
  localparam int LANES = DW / 8;

  bus_op_e  op;
  rd_mode_e mode;
  logic     rd_cycle;
  logic     wr_cycle;

  nbf_op_decode u_decode (
    .rst_n(rst_n_pin), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .op(op), .rd_cycle(rd_cycle), .wr_cycle(wr_cycle)
  );

  nbf_cmd_latch #(.AW(AW), .DW(DW)) u_latch (
    .clk(clk), .rst_n(rst_n_pin), .wr_cycle(wr_cycle), .we_n(we_n),
    .byte_mode(byte_mode), .wp(wp), .addr(addr), .din(dq_in),
    .strobe(cmd_valid), .lat_addr(cmd_addr), .lat_data(cmd_data),
    .lat_wp(cmd_unlocked)
  );

  nbf_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n_pin), .load(cmd_valid), .code(cmd_data[7:0]),
    .mode(mode)
  );

  // Read source: status overrides the stored mode while the engine works.
  always_comb begin
    if (busy) dq_out = status_data;
    else begin
      case (mode)
        RM_ARRAY:  dq_out = array_data;
        RM_CONFIG: dq_out = config_data;
        RM_STATUS: dq_out = status_data;
        default:   dq_out = query_data;
      endcase
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_oe
    if (g == 0) begin : g_low
      assign dq_oe[g] = rd_cycle;
    end else begin : g_high
      assign dq_oe[g] = rd_cycle && !byte_mode;
    end
  end

  assign bus_op    = op;
  assign read_mode = mode;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n_pin |-> (dq_oe == '0) && !cmd_valid);

  assert_standby_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n_pin)
    ce_n |-> (dq_oe == '0));

  assert_busy_status_R8: assert property (@(posedge clk) disable iff (!rst_n_pin)
    (busy && dq_oe[0]) |-> (dq_out == status_data));
endmodule

// File: tb/nor_bus_front_tb_top.sv
`timescale 1ns/1ps
module nor_bus_front_tb_top;
  localparam int AW = 21;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n_pin, ce_n, oe_n, we_n, wp, byte_mode, busy;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_in, dq_out, array_data, config_data, status_data, query_data;
  logic [1:0]    dq_oe;
  logic [2:0]    bus_op;
  logic [1:0]    read_mode;
  logic          cmd_valid, cmd_unlocked;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;

  nor_bus_front #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n_pin(rst_n_pin), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .wp(wp), .byte_mode(byte_mode), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .array_data(array_data),
    .config_data(config_data), .status_data(status_data),
    .query_data(query_data), .busy(busy), .bus_op(bus_op),
    .read_mode(read_mode), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cmd_unlocked(cmd_unlocked)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    string         tag;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic          w;
  } exp_cmd_t;
  exp_cmd_t sb_q[$];

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Monitor: every command strobe must match the head of the scoreboard.
  always @(negedge clk) begin
    #3;
    if (cmd_valid && !done) begin
      if (sb_q.size() == 0) begin
        chk("R5", "unexpected cmd_valid", 32'd1, 32'd0);
      end else begin
        exp_cmd_t e;
        e = sb_q.pop_front();
        chk(e.tag, "cmd_addr", 32'(cmd_addr), 32'(e.a));
        chk(e.tag, "cmd_data", 32'(cmd_data), 32'(e.d));
        chk("R9", "cmd_unlocked", 32'(cmd_unlocked), 32'(e.w));
      end
    end
  end

  task automatic apply(input logic r, input logic c, input logic o, input logic w);
    @(negedge clk);
    rst_n_pin = r; ce_n = c; oe_n = o; we_n = w;
    #2;
  endtask

  // Driver: one write cycle, with the expected command pushed when the strobe is due.
  task automatic do_write(input string tag, input logic [AW-1:0] a,
                          input logic [DW-1:0] d);
    logic [DW-1:0] ed;
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0; addr = a; dq_in = d;
    #2;
    chk("R12", "bus_op write", 32'(bus_op), 32'd4);
    chk("R5", "no drive in write", 32'(dq_oe), 32'd0);
    @(negedge clk);
    ed = byte_mode ? {8'h00, d[7:0]} : d;
    sb_q.push_back('{tag: tag, a: a, d: ed, w: wp});
    we_n = 1'b1;
    @(negedge clk);
    #4;
    chk("R5", "strobe ends after one cycle", 32'(cmd_valid), 32'd0);
    ce_n = 1'b1;
  endtask

  task automatic read_check(input string tag, input logic [DW-1:0] exp_d,
                            input logic [1:0] exp_oe);
    apply(1'b1, 1'b0, 1'b0, 1'b1);
    chk(tag, "dq_oe on read", 32'(dq_oe), 32'(exp_oe));
    chk(tag, "dq_out on read",
        32'(dq_out & {{8{exp_oe[1]}}, {8{exp_oe[0]}}}),
        32'(exp_d  & {{8{exp_oe[1]}}, {8{exp_oe[0]}}}));
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n_pin = 1'b0; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    wp = 1'b1; byte_mode = 1'b0; busy = 1'b0; addr = '0; dq_in = '0;
    array_data = 16'hA1A2; config_data = 16'hC3C4;
    status_data = 16'h0080; query_data = 16'h5152;

    // R1 / R6: reset state, read pattern on the other pins
    repeat (3) @(negedge clk);
    #2;
    chk("R1", "dq_oe in reset", 32'(dq_oe), 32'd0);
    chk("R12", "bus_op reset", 32'(bus_op), 32'd0);
    chk("R6", "read_mode at power-up", 32'(read_mode), 32'd0);
    apply(1'b0, 1'b0, 1'b1, 1'b0);
    apply(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R1", "no command from write in reset", 32'(cmd_valid), 32'd0);

    apply(1'b1, 1'b1, 1'b1, 1'b1);
    read_check("R4", 16'hA1A2, 2'b11);
    chk("R12", "bus_op read", 32'(bus_op), 32'd3);

    apply(1'b1, 1'b1, 1'b0, 1'b1);
    chk("R2", "standby releases bus", 32'(dq_oe), 32'd0);
    chk("R12", "bus_op standby", 32'(bus_op), 32'd1);
    apply(1'b1, 1'b1, 1'b1, 1'b0);
    apply(1'b1, 1'b1, 1'b1, 1'b1);
    chk("R2", "no command from deselected write", 32'(cmd_valid), 32'd0);

    apply(1'b1, 1'b0, 1'b1, 1'b1);
    chk("R3", "output disable releases bus", 32'(dq_oe), 32'd0);
    chk("R12", "bus_op output disable", 32'(bus_op), 32'd2);

    apply(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R11", "conflict releases bus", 32'(dq_oe), 32'd0);
    chk("R12", "bus_op conflict", 32'(bus_op), 32'd5);
    apply(1'b1, 1'b0, 1'b0, 1'b1);
    chk("R11", "no command after conflict", 32'(cmd_valid), 32'd0);
    apply(1'b1, 1'b1, 1'b1, 1'b1);

    // R7: mode commands
    do_write("R7", 21'h00055, 16'h0090);
    chk("R7", "mode config", 32'(read_mode), 32'd1);
    read_check("R4", 16'hC3C4, 2'b11);
    do_write("R7", 21'h00123, 16'h0070);
    chk("R7", "mode status", 32'(read_mode), 32'd2);
    read_check("R4", 16'h0080, 2'b11);
    do_write("R7", 21'h1ABCD, 16'h0098);
    chk("R7", "mode query", 32'(read_mode), 32'd3);
    read_check("R4", 16'h5152, 2'b11);
    do_write("R5", 21'h00200, 16'hBE40);
    chk("R7", "other code keeps mode", 32'(read_mode), 32'd3);

    // R8: busy forces status
    busy = 1'b1;
    read_check("R8", 16'h0080, 2'b11);
    apply(1'b1, 1'b1, 1'b0, 1'b1);
    chk("R2", "standby while busy", 32'(dq_oe), 32'd0);
    chk("R8", "mode kept while busy", 32'(read_mode), 32'd3);
    busy = 1'b0;
    read_check("R8", 16'h5152, 2'b11);
    apply(1'b1, 1'b1, 1'b1, 1'b1);

    // R9: write-protect low captured with command
    wp = 1'b0;
    do_write("R9", 21'h00777, 16'h0020);
    wp = 1'b1;

    // R10: byte configuration
    byte_mode = 1'b1;
    read_check("R10", 16'h5152, 2'b01);
    apply(1'b1, 1'b1, 1'b1, 1'b1);
    do_write("R10", 21'h00010, 16'h12FF);
    chk("R10", "low byte FF selects array", 32'(read_mode), 32'd0);
    read_check("R10", 16'hA1A2, 2'b01);
    byte_mode = 1'b0;
    apply(1'b1, 1'b1, 1'b1, 1'b1);

    // R6 / R1: reset pulse returns to array
    do_write("R7", 21'h00001, 16'h0098);
    chk("R7", "mode query again", 32'(read_mode), 32'd3);
    apply(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R1", "reset forces array", 32'(read_mode), 32'd0);
    chk("R1", "reset releases bus", 32'(dq_oe), 32'd0);
    apply(1'b1, 1'b1, 1'b1, 1'b1);
    read_check("R6", 16'hA1A2, 2'b11);
    chk("R6", "array after reset", 32'(read_mode), 32'd0);

    apply(1'b1, 1'b1, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    #5;
    chk("R5", "scoreboard drained", 32'(sb_q.size()), 32'd0);
    done = 1'b1;
    finish_run();
  end
endmodule